// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It combines two inputs to pick a counter. The first is a short global record of how the most recent branches resolved. The second is the low-order bits of the branch address. Each address slot holds one saturating counter for every possible history pattern, so the same branch can carry a separate bias for each recent-outcome context. With HIST_BITS history bits and CTR_BITS-bit counters this is the (HIST_BITS, CTR_BITS) arrangement. The default is two history bits, two-bit counters and four address bits, which gives 64 counters.

The fetch side presents a PC on the predict port. It gets back a combinational taken/not-taken guess and the history value that produced it. The caller keeps that history value alongside the branch. When the branch resolves, the caller presents the PC, the real outcome and the saved history on the update port. The block then trains exactly that one counter and shifts the outcome into the global history. Counters carry no tag, so branches whose low address bits match share counters.

Top module: `corr_predictor`

## Requirements
- R1: After reset the history register reads all zeros and every counter holds the weakly not-taken value (2^(CTR_BITS-1)-1, which is 1 for two-bit counters). Every PC is therefore predicted not-taken.
- R2: The counter read for a prediction is the one at index {predPc[IDX_BITS-1:0], history}, with the address bits in the upper part. Counters at the same address slot under other history values do not affect it.
- R3: Each accepted update shifts the history left by one and enters the resolved outcome (1 = taken) in bit 0. Cycles without an update leave the history unchanged. predHist always shows the current history.
- R4: predTaken is 1 exactly when the selected counter is at least 2^(CTR_BITS-1).
- R5: An update increments the selected counter on taken and decrements it on not-taken. The counter saturates at 2^CTR_BITS-1 and at 0 and never wraps.
- R6: There is no tag check. PCs that are equal in bits [IDX_BITS-1:0] use the same counters, whatever their upper bits.
- R7: An update trains the counter at index {updPc[IDX_BITS-1:0], updHist}. It uses the supplied history, not the current history register.
- R8: When a prediction and an update occur in the same cycle, predTaken and predHist reflect the state before the update. The update becomes visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| predPc | input | PC_W | Address of the branch being predicted |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| predHist | output | HIST_BITS | Current global history, to be saved with the branch |
| updValid | input | 1 | Resolved-branch update strobe |
| updPc | input | PC_W | Address of the resolved branch |
| updHist | input | HIST_BITS | History value that was seen when the branch was predicted |
| updTaken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The assertions check on every cycle that the history is unchanged between updates and that each update enters its outcome in bit 0. On every cycle they also check that a trained counter moves by at most one step and stays pinned at either end of its range. Only the bench scenarios can show which counter a given PC and history select, since that depends on the index layout. The same holds for aliasing across upper PC bits, for training through the supplied history rather than the live one, and for the prediction seeing old state in an update cycle.

// File: rtl/corr_pred_pkg.sv
package corr_pred_pkg;

  // Strobes from the update control to the datapath.
  typedef struct packed {
    logic ctrWr;      // write the selected counter this cycle
    logic ctrUp;      // direction of the write: 1 = +1, 0 = -1
    logic histShift;  // shift the global history
    logic histBit;    // bit entering the history
  } pred_strobe_t;

endpackage

// File: rtl/corr_pred_ctrl.sv
module corr_pred_ctrl
  import corr_pred_pkg::*;
#(
  parameter int CTR_BITS = 2
) (
  input  logic                updValid,
  input  logic                updTaken,
  input  logic [CTR_BITS-1:0] updCtr,
  output pred_strobe_t        strobe
);

  logic atTop;
  logic atBottom;

  assign atTop    = &updCtr;
  assign atBottom = ~|updCtr;

  always_comb begin
    strobe           = '0;
    strobe.histShift = updValid;
    strobe.histBit   = updTaken;
    strobe.ctrUp     = updTaken;
    // Skip the write when it would push past either end of the range.
    strobe.ctrWr     = updValid && (updTaken ? !atTop : !atBottom);
  end

endmodule

// File: rtl/corr_pred_dp.sv
module corr_pred_dp
  import corr_pred_pkg::*;
#(
  parameter int IDX_BITS  = 4,
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IDX_BITS-1:0]  predIdx,
  output logic                 predTaken,
  output logic [HIST_BITS-1:0] histOut,
  input  logic [IDX_BITS-1:0]  updIdxPc,
  input  logic [HIST_BITS-1:0] updHist,
  output logic [CTR_BITS-1:0]  updCtr,
  input  pred_strobe_t         strobe
);

  localparam int ADDR_W      = IDX_BITS + HIST_BITS;
  localparam int TABLE_DEPTH = 1 << ADDR_W;
  localparam logic [CTR_BITS-1:0] WEAK_NT = {1'b0, {(CTR_BITS-1){1'b1}}};
  localparam logic [CTR_BITS-1:0] CTR_ONE = {{(CTR_BITS-1){1'b0}}, 1'b1};

  logic [CTR_BITS-1:0]  ctrTable [TABLE_DEPTH];
  logic [HIST_BITS-1:0] histQ;
  logic [HIST_BITS-1:0] histNext;
  logic [ADDR_W-1:0]    predAddr;
  logic [ADDR_W-1:0]    updAddr;

  // Address slot above, history pattern below.
  assign predAddr = {predIdx, histQ};
  assign updAddr  = {updIdxPc, updHist};

  assign predTaken = ctrTable[predAddr][CTR_BITS-1];
  assign updCtr    = ctrTable[updAddr];
  assign histOut   = histQ;

  generate
    if (HIST_BITS == 1) begin : g_histOne
      assign histNext = strobe.histBit;
    end else begin : g_histWide
      assign histNext = {histQ[HIST_BITS-2:0], strobe.histBit};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      histQ <= '0;
    end else if (strobe.histShift) begin
      histQ <= histNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TABLE_DEPTH; i++) begin
        ctrTable[i] <= WEAK_NT;
      end
    end else if (strobe.ctrWr) begin
      ctrTable[updAddr] <= strobe.ctrUp ? (updCtr + CTR_ONE) : (updCtr - CTR_ONE);
    end
  end

  // R3: the history moves only on an update.
  assert_hist_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.histShift |=> $stable(histQ));

  // R3: the newest outcome lands in bit 0.
  assert_hist_enter_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.histShift |=> histQ[0] == $past(strobe.histBit));

  // R5: a trained counter moves by at most one step.
  assert_ctr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.histShift |=> (ctrTable[$past(updAddr)] == $past(updCtr)) ||
                         (ctrTable[$past(updAddr)] == $past(updCtr) + CTR_ONE) ||
                         (ctrTable[$past(updAddr)] == $past(updCtr) - CTR_ONE));

  // R5: no wrap at the top.
  assert_no_wrap_top_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.histShift && strobe.histBit && (&updCtr)) |=> (&ctrTable[$past(updAddr)]));

  // R5: no wrap at the bottom.
  assert_no_wrap_bottom_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.histShift && !strobe.histBit && !(|updCtr)) |=> !(|ctrTable[$past(updAddr)]));

endmodule

// File: rtl/corr_predictor.sv
module corr_predictor
  import corr_pred_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int IDX_BITS  = 4,
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PC_W-1:0]      predPc,
  output logic                 predTaken,
  output logic [HIST_BITS-1:0] predHist,
  input  logic                 updValid,
  input  logic [PC_W-1:0]      updPc,
  input  logic [HIST_BITS-1:0] updHist,
  input  logic                 updTaken
);

  pred_strobe_t        strobe;
  logic [CTR_BITS-1:0] updCtr;
  logic                unusedPcHigh;

  // Upper PC bits do not take part in indexing (no tag check).
  assign unusedPcHigh = ^{predPc[PC_W-1:IDX_BITS], updPc[PC_W-1:IDX_BITS]};

  corr_pred_ctrl #(
    .CTR_BITS (CTR_BITS)
  ) u_ctrl (
    .updValid (updValid),
    .updTaken (updTaken),
    .updCtr   (updCtr),
    .strobe   (strobe)
  );

  corr_pred_dp #(
    .IDX_BITS  (IDX_BITS),
    .HIST_BITS (HIST_BITS),
    .CTR_BITS  (CTR_BITS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .predIdx   (predPc[IDX_BITS-1:0]),
    .predTaken (predTaken),
    .histOut   (predHist),
    .updIdxPc  (updPc[IDX_BITS-1:0]),
    .updHist   (updHist),
    .updCtr    (updCtr),
    .strobe    (strobe)
  );

endmodule

// File: tb/sim_corr_predictor.sv
`timescale 1ns/1ps
module sim_corr_predictor;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] predPc;
  logic        predTaken;
  logic [1:0]  predHist;
  logic        updValid;
  logic [31:0] updPc;
  logic [1:0]  updHist;
  logic        updTaken;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  int         modelCtr [64];
  logic [1:0] modelHist;

  always #2.5 clk = ~clk;

  corr_predictor u0 (
    .clk(clk), .rstN(rstN), .predPc(predPc), .predTaken(predTaken),
    .predHist(predHist), .updValid(updValid), .updPc(updPc),
    .updHist(updHist), .updTaken(updTaken)
  );

  function automatic int idxOf(logic [31:0] pc, logic [1:0] h);
    return int'({pc[3:0], h});
  endfunction

  task automatic checkEq(int got, int exp, string tag);
    vectors++;
    if (got != exp) begin
      misses++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic checkPred(logic [31:0] pc, string tag);
    predPc = pc;
    #1;
    checkEq(int'(predTaken), (modelCtr[idxOf(pc, modelHist)] >= 2) ? 1 : 0, tag);
  endtask

  task automatic checkHist(string tag);
    #1;
    checkEq(int'(predHist), int'(modelHist), tag);
  endtask

  task automatic resetDut();
    rstN = 1'b0; updValid = 1'b0; updPc = '0; updHist = '0; updTaken = 1'b0; predPc = '0;
    for (int i = 0; i < 64; i++) modelCtr[i] = 1;
    modelHist = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic modelUpdate(logic [31:0] pc, logic [1:0] h, logic t);
    int k;
    k = idxOf(pc, h);
    if (t && modelCtr[k] < 3) modelCtr[k]++;
    if (!t && modelCtr[k] > 0) modelCtr[k]--;
    modelHist = {modelHist[0], t};
  endtask

  // Called at a falling edge; returns at the falling edge after the write.
  task automatic doUpdate(logic [31:0] pc, logic [1:0] h, logic t);
    updValid = 1'b1; updPc = pc; updHist = h; updTaken = t;
    @(posedge clk);
    modelUpdate(pc, h, t);
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic testReset();
    resetDut();
    checkHist("R1 history cleared");
    for (int p = 0; p < 16; p++) begin
      predPc = 32'(p); #1;
      checkEq(int'(predTaken), 0, "R1 weak not-taken after reset");
    end
  endtask

  task automatic testHistSelect();
    resetDut();
    doUpdate(32'h5, 2'b00, 1'b1);
    doUpdate(32'h5, 2'b00, 1'b1);           // history now 11
    predPc = 32'h5; #1;
    checkEq(int'(predTaken), 0, "R2 other history counter untouched");
    doUpdate(32'h9, 2'b11, 1'b0);
    doUpdate(32'h9, 2'b11, 1'b0);           // history back to 00
    predPc = 32'h5; #1;
    checkEq(int'(predTaken), 1, "R2 trained counter selected by history 00");
    checkPred(32'h9, "R2 model slot 9");
  endtask

  task automatic testHistShift();
    resetDut();
    doUpdate(32'h1, 2'b00, 1'b1);
    checkEq(int'(predHist), 1, "R3 taken enters bit 0");
    doUpdate(32'h1, 2'b00, 1'b0);
    checkEq(int'(predHist), 2, "R3 older outcome moves to bit 1");
    repeat (4) @(negedge clk);
    checkEq(int'(predHist), 2, "R3 history holds without update");
    checkHist("R3 model history");
  endtask

  task automatic testThresholdSat();
    resetDut();
    repeat (4) doUpdate(32'h2, 2'b00, 1'b1);   // 1 -> 2 -> 3 -> 3 -> 3
    doUpdate(32'h2, 2'b00, 1'b0);              // -> 2
    doUpdate(32'h7, 2'b00, 1'b0);
    doUpdate(32'h7, 2'b00, 1'b0);              // history 00
    predPc = 32'h2; #1;
    checkEq(int'(predTaken), 1, "R5 saturated high, one decrement still taken");
    doUpdate(32'h2, 2'b00, 1'b0);              // -> 1, history 00
    predPc = 32'h2; #1;
    checkEq(int'(predTaken), 0, "R4 value 1 below threshold");
    doUpdate(32'h7, 2'b00, 1'b1);              // slot 7 was pinned at 0 -> 1
    doUpdate(32'h7, 2'b01, 1'b0);              // history 10
    doUpdate(32'h3, 2'b10, 1'b0);              // history 00
    checkPred(32'h7, "R5 low saturation no wrap");
    predPc = 32'h7; #1;
    checkEq(int'(predTaken), 0, "R5 slot 7 at 1 after bottom pin");
    doUpdate(32'h7, 2'b00, 1'b1);              // slot 7 at 00 -> 2, history 01
    doUpdate(32'h3, 2'b01, 1'b0);              // history 10
    doUpdate(32'h3, 2'b10, 1'b0);              // history 00
    predPc = 32'h7; #1;
    checkEq(int'(predTaken), 1, "R4 value 2 meets threshold");
  endtask

  task automatic testAlias();
    resetDut();
    doUpdate(32'hABCD_0013, 2'b00, 1'b1);
    doUpdate(32'h0000_0F03, 2'b01, 1'b0);      // history 10
    doUpdate(32'h1234_5673, 2'b10, 1'b0);      // history 00
    predPc = 32'h0000_0003; #1;
    checkEq(int'(predTaken), 1, "R6 alias shares trained counter");
    checkPred(32'hFFFF_FFF3, "R6 alias upper bits ignored");
  endtask

  task automatic testUpdHist();
    resetDut();
    doUpdate(32'h4, 2'b11, 1'b1);
    doUpdate(32'h4, 2'b11, 1'b1);              // history now 11
    predPc = 32'h4; #1;
    checkEq(int'(predTaken), 1, "R7 supplied history picks counter");
    checkPred(32'h4, "R7 model check");
  endtask

  task automatic testSameCycle();
    resetDut();
    updValid = 1'b1; updPc = 32'h6; updHist = 2'b00; updTaken = 1'b1;
    predPc = 32'h6; #1;
    checkEq(int'(predTaken), 0, "R8 prediction sees pre-update counter");
    checkEq(int'(predHist), 0, "R8 history pre-update in same cycle");
    @(posedge clk);
    modelUpdate(32'h6, 2'b00, 1'b1);
    @(negedge clk);
    updValid = 1'b0;
    checkEq(int'(predHist), 1, "R8 update visible next cycle");
    checkPred(32'h6, "R8 model after update");
  endtask

  initial begin
    testReset();
    testHistSelect();
    testHistShift();
    testThresholdSat();
    testAlias();
    testUpdHist();
    testSameCycle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule